// File: doc/BRIEF.md
# SD Host Error and Interrupt Collector

This block gathers the error and event conditions of a small SD/MMC host controller into one sticky status word and folds them, through a per-source mask and a global enable, into a single registered interrupt line. The command path and the data path report their conditions as one-cycle pulses. The block also owns two checks that software can trip. The first is the command holding buffer: a start request while a command is still held is refused and flagged as a locked error. The second is the software FIFO port: a write into a full FIFO or a read from an empty one is blocked and flagged.

Software reaches the block through a plain synchronous register port. Reads return data one cycle after the address is presented. Status bits stay set until software writes 1 to their position. A data CRC error seen during a multi-block write is only recorded. It does not cancel the held command and does not block FIFO traffic, so the transfer runs to its end.

Top module: `sdh_err_irq_top`

## Requirements
- R1: After reset the enable bit, the mask, the status word, the pending-command flag and the interrupt output are all 0.
- R2: A pulse on a source sets its status bit in the next cycle. The bits are: cmd_evt_i[0] response timeout to bit 0, [1] response error to bit 1, [2] response CRC error to bit 2, and dat_evt_i[0..4] to bits 3..7 (data timeout, data CRC, start bit missing, end bit missing, host starvation timeout). The bit then stays set.
- R3: A write to address 2 clears exactly the status bits written as 1. A source pulse in the same cycle as the clear of its bit leaves that bit set.
- R4: irq_o in cycle t+1 equals enable AND the OR over (status AND mask) as they stand in cycle t.
- R5: cmd_start_i with no command held raises cmd_accept_o in the same cycle, and cmd_pending_o is 1 from the next cycle.
- R6: cmd_start_i while a command is held and cmd_taken_i is low gives cmd_accept_o = 0, leaves the held command in place, and sets status bit 8.
- R7: cmd_taken_i frees the buffer at the next cycle. A cmd_start_i in the same cycle is accepted, and the buffer stays occupied.
- R8: sw_fifo_wr_i while fifo_full_i is high gives fifo_wr_ok_o = 0 and sets status bit 9. Otherwise fifo_wr_ok_o follows sw_fifo_wr_i.
- R9: sw_fifo_rd_i while fifo_empty_i is high gives fifo_rd_ok_o = 0 and sets status bit 10. Otherwise fifo_rd_ok_o follows sw_fifo_rd_i.
- R10: The register map is:
  - address 0: enable in bit 0, read/write;
  - address 1: mask in bits 10:0, read/write;
  - address 2: status, read, and write-1-to-clear;
  - address 3: read-only flags, with full in bit 0, empty in bit 1 and pending in bit 2.

  Other addresses read 0, and writes to them or to address 3 change nothing. reg_rdata_o holds the value of the address presented one cycle earlier.
- R11: A data CRC pulse sets only bit 4. It leaves the held command, cmd_accept_o, fifo_wr_ok_o and fifo_rd_ok_o unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_evt_i | input | 3 | Command-path error pulses |
| dat_evt_i | input | 5 | Data-path error pulses |
| cmd_start_i | input | 1 | Software start-command request |
| cmd_taken_i | input | 1 | Command path has consumed the held command |
| cmd_accept_o | output | 1 | Start request accepted this cycle |
| cmd_pending_o | output | 1 | A command is held |
| sw_fifo_wr_i | input | 1 | Software FIFO write strobe |
| sw_fifo_rd_i | input | 1 | Software FIFO read strobe |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_wr_ok_o | output | 1 | Write forwarded to the FIFO |
| fifo_rd_ok_o | output | 1 | Read forwarded to the FIFO |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle latency |
| irq_o | output | 1 | Registered interrupt |

## Verification
Directed cases exercise the paths one at a time:
- each source is pulsed alone, which separates the bit mapping from cross-talk between bits;
- a clear is made to coincide with a new event, which tells a set-priority bit from a clear-priority one;
- start is combined with taken and with an occupied buffer, which tells a correct release from an early or late one;
- strobes are issued against each FIFO flag level.

A long random run with a fixed seed then mixes sparse pulses, writes to all addresses and random flag levels against a cycle model. This exposes wrong read latency, a missing interrupt register stage and masking faults that single cases would hide.

// File: rtl/sdh_err_pkg.sv
// Package: shared constants for the SD host error collector.
// Holds source counts, status bit positions and register addresses.
package sdh_err_pkg;
    localparam int CMD_EVT_N = 3;
    localparam int DAT_EVT_N = 5;
    localparam int IDX_LOCK  = CMD_EVT_N + DAT_EVT_N;
    localparam int IDX_OVR   = IDX_LOCK + 1;
    localparam int IDX_UND   = IDX_LOCK + 2;
    localparam int SRC_N     = IDX_LOCK + 3;

    localparam int ADR_CTRL  = 0;
    localparam int ADR_MASK  = 1;
    localparam int ADR_RAW   = 2;
    localparam int ADR_FLAGS = 3;
endpackage

// File: rtl/sdh_cmd_gate.sv
// Module: command holding buffer guard.
// Accepts a start request when the buffer is free, or when it is freed in
// the same cycle. Otherwise it refuses the request and pulses a locked event.
// Assumes cmd_taken_i is only raised while a command is held.
module sdh_cmd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic taken_i,
    output logic accept_o,
    output logic pending_o,
    output logic locked_o
);
    logic pend_q;
    logic free_now;

    // Decide acceptance from the current occupancy and the release.
    always_comb begin
        free_now = !pend_q || taken_i;
        accept_o = start_i && free_now;
        locked_o = start_i && !free_now;
    end

    // Track buffer occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (accept_o)
            pend_q <= 1'b1;
        else if (taken_i)
            pend_q <= 1'b0;
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/sdh_fifo_guard.sv
// Module: software FIFO access guard.
// Blocks writes into a full FIFO and reads from an empty one, and reports
// each blocked access as a one-cycle event. Purely combinational.
module sdh_fifo_guard (
    input  logic wr_i,
    input  logic rd_i,
    input  logic full_i,
    input  logic empty_i,
    output logic wr_ok_o,
    output logic rd_ok_o,
    output logic ovr_o,
    output logic und_o
);
    // Gate strobes against the flags.
    always_comb begin
        wr_ok_o = wr_i && !full_i;
        rd_ok_o = rd_i && !empty_i;
        ovr_o   = wr_i && full_i;
        und_o   = rd_i && empty_i;
    end
endmodule

// File: rtl/sdh_sticky_stat.sv
// Module: sticky status bits with write-1-to-clear.
// Each bit is set by its event and cleared only by its clear bit. When both
// occur in the same cycle, the set wins.
module sdh_sticky_stat #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] raw_o
);
    logic [N-1:0] raw_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                raw_q[i] <= 1'b0;
            else if (set_i[i])
                raw_q[i] <= 1'b1;
            else if (clr_i[i])
                raw_q[i] <= 1'b0;
        end
    end

    assign raw_o = raw_q;
endmodule

// File: rtl/sdh_err_csr.sv
// Module: register port and interrupt stage.
// Holds the enable and mask registers, decodes status clears, returns read
// data one cycle after the address, and registers the interrupt.
// Assumes DATA_W >= SRC_N and DATA_W >= 3.
module sdh_err_csr
    import sdh_err_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_N-1:0]  raw_i,
    input  logic              full_i,
    input  logic              empty_i,
    input  logic              pending_i,
    output logic [SRC_N-1:0]  clr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(ADR_MASK);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(ADR_RAW);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADR_FLAGS);

    logic              en_q;
    logic [SRC_N-1:0]  mask_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;
    logic              wdata_unused;

    assign wdata_unused = ^wdata_i;

    // Decode the write-1-to-clear strobe for the status word.
    always_comb begin
        clr_o = '0;
        if (wr_i && addr_i == A_RAW)
            clr_o = wdata_i[SRC_N-1:0];
    end

    // Enable and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= '0;
        end else if (wr_i) begin
            if (addr_i == A_CTRL) en_q   <= wdata_i[0];
            if (addr_i == A_MASK) mask_q <= wdata_i[SRC_N-1:0];
        end
    end

    // Select read data by address.
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            A_CTRL:  rd_mux[0]         = en_q;
            A_MASK:  rd_mux[SRC_N-1:0] = mask_q;
            A_RAW:   rd_mux[SRC_N-1:0] = raw_i;
            A_FLAGS: rd_mux[2:0]       = {pending_i, empty_i, full_i};
            default: rd_mux            = '0;
        endcase
    end

    // Read data register and glitch-free interrupt stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            rdata_q <= rd_mux;
            irq_q   <= en_q && (|(raw_i & mask_q));
        end
    end

    assign rdata_o = rdata_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/sdh_err_irq_top.sv
// Module: SD host error and interrupt collector, top level.
// Combines command-path and data-path pulses with the command buffer and
// FIFO guards into a sticky status word, and masks it into one interrupt.
// Assumes the event inputs are synchronous one-cycle pulses.
module sdh_err_irq_top
    import sdh_err_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CMD_EVT_N-1:0] cmd_evt_i,
    input  logic [DAT_EVT_N-1:0] dat_evt_i,
    input  logic                 cmd_start_i,
    input  logic                 cmd_taken_i,
    output logic                 cmd_accept_o,
    output logic                 cmd_pending_o,
    input  logic                 sw_fifo_wr_i,
    input  logic                 sw_fifo_rd_i,
    input  logic                 fifo_full_i,
    input  logic                 fifo_empty_i,
    output logic                 fifo_wr_ok_o,
    output logic                 fifo_rd_ok_o,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 irq_o
);
    logic             locked_evt;
    logic             ovr_evt;
    logic             und_evt;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] raw_q;

    sdh_cmd_gate u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cmd_start_i),
        .taken_i   (cmd_taken_i),
        .accept_o  (cmd_accept_o),
        .pending_o (cmd_pending_o),
        .locked_o  (locked_evt)
    );

    sdh_fifo_guard u_fifo (
        .wr_i    (sw_fifo_wr_i),
        .rd_i    (sw_fifo_rd_i),
        .full_i  (fifo_full_i),
        .empty_i (fifo_empty_i),
        .wr_ok_o (fifo_wr_ok_o),
        .rd_ok_o (fifo_rd_ok_o),
        .ovr_o   (ovr_evt),
        .und_o   (und_evt)
    );

    // Assemble the event vector in status bit order.
    assign set_vec = {und_evt, ovr_evt, locked_evt, dat_evt_i, cmd_evt_i};

    sdh_sticky_stat #(.N(SRC_N)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .raw_o (raw_q)
    );

    sdh_err_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .raw_i     (raw_q),
        .full_i    (fifo_full_i),
        .empty_i   (fifo_empty_i),
        .pending_i (cmd_pending_o),
        .clr_o     (clr_vec),
        .rdata_o   (reg_rdata_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/sdh_err_irq_chk.sv
// Module: property checker for the SD host error collector, bound to the top.
module sdh_err_irq_chk
    import sdh_err_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CMD_EVT_N-1:0] cmd_evt_i,
    input logic [DAT_EVT_N-1:0] dat_evt_i,
    input logic                 cmd_start_i,
    input logic                 cmd_taken_i,
    input logic                 cmd_accept_o,
    input logic                 cmd_pending_o,
    input logic                 sw_fifo_wr_i,
    input logic                 sw_fifo_rd_i,
    input logic                 fifo_full_i,
    input logic                 fifo_empty_i,
    input logic                 fifo_wr_ok_o,
    input logic                 fifo_rd_ok_o,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic                 reg_wr_i,
    input logic [DATA_W-1:0]    reg_wdata_i,
    input logic [SRC_N-1:0]     raw_q,
    input logic                 irq_o
);
    localparam int PULSE_N = CMD_EVT_N + DAT_EVT_N;
    logic [PULSE_N-1:0] pulses;
    assign pulses = {dat_evt_i, cmd_evt_i};

    for (genvar i = 0; i < PULSE_N; i++) begin : g_src
        // R2
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulses[i] |=> raw_q[i]);
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_hold
        // R3
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            raw_q[i] && !(reg_wr_i && reg_addr_i == ADDR_W'(ADR_RAW) && reg_wdata_i[i])
            |=> raw_q[i]);
    end

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|raw_q));

    // R6
    lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_i && cmd_pending_o && !cmd_taken_i |-> !cmd_accept_o);

    // R6
    lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_i && cmd_pending_o && !cmd_taken_i |=> raw_q[IDX_LOCK] && cmd_pending_o);

    // R7
    release_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_i && cmd_taken_i |-> cmd_accept_o);

    // R8
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fifo_wr_i && fifo_full_i |-> !fifo_wr_ok_o);

    // R8
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fifo_wr_i && fifo_full_i |=> raw_q[IDX_OVR]);

    // R9
    underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fifo_rd_i && fifo_empty_i |-> !fifo_rd_ok_o);

    // R9
    underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fifo_rd_i && fifo_empty_i |=> raw_q[IDX_UND]);
endmodule

bind sdh_err_irq_top sdh_err_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_evt_i     (cmd_evt_i),
    .dat_evt_i     (dat_evt_i),
    .cmd_start_i   (cmd_start_i),
    .cmd_taken_i   (cmd_taken_i),
    .cmd_accept_o  (cmd_accept_o),
    .cmd_pending_o (cmd_pending_o),
    .sw_fifo_wr_i  (sw_fifo_wr_i),
    .sw_fifo_rd_i  (sw_fifo_rd_i),
    .fifo_full_i   (fifo_full_i),
    .fifo_empty_i  (fifo_empty_i),
    .fifo_wr_ok_o  (fifo_wr_ok_o),
    .fifo_rd_ok_o  (fifo_rd_ok_o),
    .reg_addr_i    (reg_addr_i),
    .reg_wr_i      (reg_wr_i),
    .reg_wdata_i   (reg_wdata_i),
    .raw_q         (raw_q),
    .irq_o         (irq_o)
);

// File: tb/sdh_err_irq_top_tb_top.sv
// Bench: directed corner cases followed by seeded random traffic, compared
// each cycle against a cycle model built from the requirements.
module sdh_err_irq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cmd_evt;
    logic [4:0]  dat_evt;
    logic        cmd_start, cmd_taken, cmd_accept, cmd_pending;
    logic        sw_wr, sw_rd, f_full, f_empty, wr_ok, rd_ok;
    logic [2:0]  addr;
    logic        rwr;
    logic [31:0] wdata, rdata;
    logic        irq;

    int checks   = 0;
    int failures = 0;

    logic [10:0] m_raw, m_mask;
    logic        m_en, m_pend, m_irq;
    logic [31:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdh_err_irq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_evt_i(cmd_evt), .dat_evt_i(dat_evt),
        .cmd_start_i(cmd_start), .cmd_taken_i(cmd_taken),
        .cmd_accept_o(cmd_accept), .cmd_pending_o(cmd_pending),
        .sw_fifo_wr_i(sw_wr), .sw_fifo_rd_i(sw_rd),
        .fifo_full_i(f_full), .fifo_empty_i(f_empty),
        .fifo_wr_ok_o(wr_ok), .fifo_rd_ok_o(rd_ok),
        .reg_addr_i(addr), .reg_wr_i(rwr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {31'd0, m_en};
            3'd1: return {21'd0, m_mask};
            3'd2: return {21'd0, m_raw};
            3'd3: return {29'd0, m_pend, f_empty, f_full};
            default: return 32'd0;
        endcase
    endfunction

    task automatic pulses_off();
        cmd_evt = '0; dat_evt = '0; cmd_start = 0; cmd_taken = 0;
        sw_wr = 0; sw_rd = 0; rwr = 0; wdata = '0;
    endtask

    // One cycle: inputs are already driven after a falling edge.
    task automatic tick();
        logic        acc, lock, irq_n;
        logic [10:0] ev, clr;
        logic [31:0] rd;
        string       rtag;
        #1;
        lock = cmd_start && m_pend && !cmd_taken;
        acc  = cmd_start && (!m_pend || cmd_taken);
        chk({31'd0, cmd_accept}, {31'd0, acc}, lock ? "R6" : (cmd_taken ? "R7" : "R5"));
        chk({31'd0, wr_ok}, {31'd0, sw_wr && !f_full}, "R8");
        chk({31'd0, rd_ok}, {31'd0, sw_rd && !f_empty}, "R9");
        @(posedge clk);
        rd    = model_read(addr);
        rtag  = (addr == 3'd2) ? "R2" : "R10";
        irq_n = m_en && (|(m_raw & m_mask));
        ev    = {sw_rd && f_empty, sw_wr && f_full, lock, dat_evt, cmd_evt};
        clr   = (rwr && addr == 3'd2) ? wdata[10:0] : 11'd0;
        if (clr != 0) rtag = "R3";
        m_raw = (m_raw & ~clr) | ev;
        if (rwr && addr == 3'd0) m_en   = wdata[0];
        if (rwr && addr == 3'd1) m_mask = wdata[10:0];
        m_pend = acc ? 1'b1 : (cmd_taken ? 1'b0 : m_pend);
        m_irq  = irq_n;
        m_rd   = rd;
        @(negedge clk);
        chk(rdata, m_rd, rtag);
        chk({31'd0, irq}, {31'd0, m_irq}, "R4");
        chk({31'd0, cmd_pending}, {31'd0, m_pend}, "R5");
        pulses_off();
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        addr = a; tick(); tick(); v = rdata;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        addr = a; rwr = 1; wdata = d; tick();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0C0D));
        pulses_off();
        addr = 0; f_full = 0; f_empty = 0; rst_n = 0;
        m_raw = 0; m_mask = 0; m_en = 0; m_pend = 0; m_irq = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk({31'd0, irq}, 0, "R1");
        chk({31'd0, cmd_pending}, 0, "R1");
        for (int a = 0; a < 3; a++) begin
            rd_reg(3'(a), v);
            chk(v, 0, "R1");
        end

        // R2: each pulse source alone, then clear
        for (int b = 0; b < 8; b++) begin
            addr = 3'd2;
            if (b < 3) cmd_evt[b] = 1'b1; else dat_evt[b-3] = 1'b1;
            tick();
            rd_reg(3'd2, v);
            chk(v, 32'd1 << b, "R2");
            wr_reg(3'd2, 32'h7FF);
            rd_reg(3'd2, v);
            chk(v, 0, "R3");
        end

        // R3: clear and new event of the same bit in one cycle
        cmd_evt[0] = 1; tick();
        addr = 3'd2; rwr = 1; wdata = 32'h1; cmd_evt[0] = 1; tick();
        rd_reg(3'd2, v);
        chk(v, 32'h1, "R3");
        wr_reg(3'd2, 32'h7FF);

        // R4: registered masked interrupt
        wr_reg(3'd0, 1);
        wr_reg(3'd1, 32'h8);
        dat_evt[0] = 1; tick();
        chk({31'd0, irq}, 0, "R4");
        tick();
        chk({31'd0, irq}, 1, "R4");
        wr_reg(3'd1, 32'h0); tick();
        chk({31'd0, irq}, 0, "R4");
        wr_reg(3'd1, 32'h8); wr_reg(3'd0, 0); tick();
        chk({31'd0, irq}, 0, "R4");
        wr_reg(3'd2, 32'h7FF);

        // R5 R6 R7: command buffer
        cmd_start = 1; #1 chk({31'd0, cmd_accept}, 1, "R5"); tick();
        cmd_start = 1; #1 chk({31'd0, cmd_accept}, 0, "R6"); tick();
        rd_reg(3'd2, v);
        chk(v, 32'h100, "R6");
        cmd_start = 1; cmd_taken = 1; #1 chk({31'd0, cmd_accept}, 1, "R7"); tick();
        chk({31'd0, cmd_pending}, 1, "R7");
        cmd_taken = 1; tick();
        chk({31'd0, cmd_pending}, 0, "R7");
        wr_reg(3'd2, 32'h7FF);

        // R8 R9: FIFO misuse
        f_full = 1; sw_wr = 1; #1 chk({31'd0, wr_ok}, 0, "R8"); tick();
        f_full = 0; f_empty = 1; sw_rd = 1; #1 chk({31'd0, rd_ok}, 0, "R9"); tick();
        f_empty = 0;
        rd_reg(3'd2, v);
        chk(v, 32'h600, "R8");
        wr_reg(3'd2, 32'h7FF);

        // R10: read-only and unmapped addresses
        wr_reg(3'd3, 32'hFFFF_FFFF);
        wr_reg(3'd5, 32'hFFFF_FFFF);
        rd_reg(3'd5, v); chk(v, 0, "R10");
        f_full = 1;
        rd_reg(3'd3, v); chk(v, 32'h1, "R10");
        f_full = 0;
        rd_reg(3'd0, v); chk(v, 0, "R10");

        // R11: data CRC during a write transfer does not stop it
        cmd_start = 1; tick();
        dat_evt[1] = 1; sw_wr = 1;
        #1 chk({31'd0, wr_ok}, 1, "R11");
        tick();
        chk({31'd0, cmd_pending}, 1, "R11");
        rd_reg(3'd2, v); chk(v, 32'h10, "R11");
        cmd_taken = 1; tick();
        wr_reg(3'd2, 32'h7FF);

        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            cmd_evt   = ($urandom % 6 == 0) ? 3'($urandom) : 3'd0;
            dat_evt   = ($urandom % 6 == 0) ? 5'($urandom) : 5'd0;
            cmd_start = ($urandom % 4 == 0);
            cmd_taken = m_pend && ($urandom % 3 == 0);
            sw_wr     = ($urandom % 3 == 0);
            sw_rd     = ($urandom % 3 == 0);
            f_full    = ($urandom % 4 == 0);
            f_empty   = !f_full && ($urandom % 4 == 0);
            addr      = 3'($urandom);
            rwr       = ($urandom % 5 == 0);
            wdata     = $urandom;
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule